// File: doc/BRIEF.md
# Byte/Pair Register File with Two-Step Pair Adder

This block holds seven byte-wide working registers: A, B, C, D, E, H and L. Six of them also combine into three 16-bit pairs: BC, DE and HL. The first-named register of each pair is the high byte. The same storage is visible both ways. A byte write shows up in the pair read, and a pair write shows up in the two byte reads. The HL pair is always presented on a dedicated output, so that a memory stage can use it as an operand address.

A pair-add command adds a selected pair into HL using a single byte-wide adder.

- On the edge that accepts the command, the low bytes are added and the result lands in L.
- On the following edge, the high bytes are added together with the carry from the first step, and the result lands in H.
- The carry out of the high step is latched as the carry flag. No other state changes.
- A busy output covers the second step. A one-cycle done pulse follows it.

Reads are combinational. All state changes on the rising clock edge. Reset is synchronous and active low.

Top module: `pairreg_file`

## Requirements
- R1: While reset is held low across a rising edge, all seven registers, the carry flag, busy and done are cleared to zero.
- R2: Byte index encoding is 0=A, 1=B, 2=C, 3=D, 4=E, 5=H, 6=L. A byte write lands on the next edge. The byte read is combinational. A write to index 7 is ignored, and a read of index 7 returns zero.
- R3: Pair select encoding is 0=BC, 1=DE, 2=HL, with the first-named register in bits [15:8]. A pair write updates both bytes, which are then visible through byte reads. Select 3 is ignored on writes and reads as zero.
- R4: The address output always equals HL, that is {H, L}.
- R5: A pair-add started while idle, with select 0 to 2, sets HL to (HL + pair) mod 65536. L takes its new value on the start edge. H takes its new value on the next edge, including the low-step carry.
- R6: After an accepted start, busy is high for exactly one cycle, and done is high for exactly the one cycle after that. A start issued while busy is ignored.
- R7: The carry flag equals the carry out of the high-byte step. It changes only in the done cycle, and byte or pair writes leave it unchanged.
- R8: Adding HL to itself is allowed and yields 2*HL mod 65536.
- R9: When a byte write and a pair write occur in the same cycle, the pair write is applied and the byte write is dropped entirely.
- R10: A pair-add start with select 3 is ignored: no busy, no done, no register change.
- R11: On an edge where the adder writes L or H, that adder write overrides any byte or pair write to the same register. Other registers still accept the port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_rd_idx | input | 3 | Byte read index |
| byte_rd_data | output | 8 | Byte read data (combinational) |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wr_idx | input | 3 | Byte write index |
| byte_wr_data | input | 8 | Byte write data |
| pair_rd_sel | input | 2 | Pair read select |
| pair_rd_data | output | 16 | Pair read data, high byte in [15:8] |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_sel | input | 2 | Pair write select |
| pair_wr_data | input | 16 | Pair write data |
| mem_addr | output | 16 | Current HL value for operand addressing |
| add_start | input | 1 | Pair-add command |
| add_src_sel | input | 2 | Pair added into HL |
| add_busy | output | 1 | High-byte step in progress |
| add_done | output | 1 | One-cycle completion pulse |
| carry_flag | output | 1 | Carry out of the last pair-add |

## Verification
The pair-add is driven with several operand patterns, each aimed at a different fault:

| Pattern | What it separates |
|---|---|
| Sum without any carry | Baseline addition |
| Low byte of 0xFF plus one | Carry passed from the low step into the high step |
| Full 0xFFFF wrap | Whether the carry flag is latched |
| HL added to itself | Source operand corrupted by the low-step write |
| Start issued while busy, and start with select 3 | Whether the command handshake ignores them |
| Writes to H and L during an addition | The write priority of R11 |

Random port traffic runs against a behavioural model that is compared every cycle. This exposes crossed byte and pair mappings, and a collision rule with the wrong winner.

// File: rtl/pairreg_pkg.sv
// Package: shared indices, encodings and helpers for the byte/pair register file.
// Assumes exactly seven byte registers; the pair layout is fixed by the architecture.
package pairreg_pkg;

    localparam int unsigned NUM_REGS = 7;
    localparam int unsigned IDX_W    = 3;
    localparam int unsigned SEL_W    = 2;

    typedef enum logic [IDX_W-1:0] {
        REG_A = 3'd0, REG_B = 3'd1, REG_C = 3'd2, REG_D = 3'd3,
        REG_E = 3'd4, REG_H = 3'd5, REG_L = 3'd6
    } reg_idx_e;

    typedef enum logic [SEL_W-1:0] {
        PAIR_BC = 2'd0, PAIR_DE = 2'd1, PAIR_HL = 2'd2
    } pair_sel_e;

    typedef enum logic {
        ADD_IDLE = 1'b0,
        ADD_HIGH = 1'b1
    } add_state_e;

    // Index of the high-byte register of a pair (valid for select 0..2).
    function automatic logic [IDX_W-1:0] pair_hi_idx(input logic [SEL_W-1:0] sel);
        return {sel, 1'b1};
    endfunction

    // Index of the low-byte register of a pair (valid for select 0..2).
    function automatic logic [IDX_W-1:0] pair_lo_idx(input logic [SEL_W-1:0] sel);
        return {sel, 1'b1} + 3'd1;
    endfunction

    // True when a select value names a real pair.
    function automatic logic pair_valid(input logic [SEL_W-1:0] sel);
        return sel != 2'd3;
    endfunction

endpackage

// File: rtl/pairreg_step_add.sv
// Module: one byte-wide add step with carry in and carry out.
// Assumes nothing about operand origin; purely combinational.
module pairreg_step_add #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o
);

    // Full add of two bytes plus incoming carry.
    always_comb begin
        {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
    end

endmodule

// File: rtl/pairreg_adder.sv
// Module: sequencer for the 16-bit pair-add on a single byte-wide adder.
// Step 1 on the accepting edge: L + src_lo, carry kept; step 2 on the next edge:
// H + src_hi + kept carry. src_hi is captured at start so later writes cannot
// disturb the operand. Assumes the caller applies lo/hi writes with top priority.
module pairreg_adder
    import pairreg_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic [DW-1:0]    src_lo_i,
    input  logic [DW-1:0]    src_hi_i,
    input  logic [DW-1:0]    l_i,
    input  logic [DW-1:0]    h_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             carry_o,
    output logic             lo_we_o,
    output logic [DW-1:0]    lo_wd_o,
    output logic             hi_we_o,
    output logic [DW-1:0]    hi_wd_o
);

    add_state_e    state_q;
    logic [DW-1:0] hi_opnd_q;
    logic          c_mid_q;
    logic          done_q;
    logic          carry_q;

    logic          accept;
    logic [DW-1:0] op_a, op_b, sum;
    logic          op_cin, cout;

    // Command acceptance: idle and a real pair selected.
    always_comb begin
        accept = start_i && (state_q == ADD_IDLE) && pair_valid(src_sel_i);
    end

    // Operand steering into the shared byte adder.
    always_comb begin
        if (state_q == ADD_HIGH) begin
            op_a   = h_i;
            op_b   = hi_opnd_q;
            op_cin = c_mid_q;
        end else begin
            op_a   = l_i;
            op_b   = src_lo_i;
            op_cin = 1'b0;
        end
    end

    pairreg_step_add #(.DW(DW)) u_step (
        .a_i    (op_a),
        .b_i    (op_b),
        .cin_i  (op_cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // Step control: sequence low then high step, latch carry, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ADD_IDLE;
            hi_opnd_q <= '0;
            c_mid_q   <= 1'b0;
            done_q    <= 1'b0;
            carry_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ADD_IDLE: begin
                    if (accept) begin
                        hi_opnd_q <= src_hi_i;
                        c_mid_q   <= cout;
                        state_q   <= ADD_HIGH;
                    end
                end
                default: begin
                    carry_q <= cout;
                    done_q  <= 1'b1;
                    state_q <= ADD_IDLE;
                end
            endcase
        end
    end

    assign busy_o  = (state_q == ADD_HIGH);
    assign done_o  = done_q;
    assign carry_o = carry_q;
    assign lo_we_o = accept;
    assign lo_wd_o = sum;
    assign hi_we_o = (state_q == ADD_HIGH);
    assign hi_wd_o = sum;

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);
    // R6
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (done_o && !busy_o));
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(carry_o));
    // R10
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !pair_valid(src_sel_i)) |=> !busy_o);

endmodule

// File: rtl/pairreg_bank.sv
// Module: storage for the seven byte registers with per-register write priority.
// Priority per register: adder step > pair write > byte write. A byte write is
// dropped whenever a pair write is enabled. Assumes invalid selects/indices are no-ops.
module pairreg_bank
    import pairreg_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_we_i,
    input  logic [IDX_W-1:0]             byte_idx_i,
    input  logic [DW-1:0]                byte_wd_i,
    input  logic                         pair_we_i,
    input  logic [SEL_W-1:0]             pair_sel_i,
    input  logic [2*DW-1:0]              pair_wd_i,
    input  logic                         lo_we_i,
    input  logic [DW-1:0]                lo_wd_i,
    input  logic                         hi_we_i,
    input  logic [DW-1:0]                hi_wd_i,
    output logic [NUM_REGS-1:0][DW-1:0]  regs_o
);

    logic [IDX_W-1:0] pw_hi, pw_lo;
    logic             pw_ok;

    // Decode which registers a pair write targets.
    always_comb begin
        pw_hi = pair_hi_idx(pair_sel_i);
        pw_lo = pair_lo_idx(pair_sel_i);
        pw_ok = pair_we_i && pair_valid(pair_sel_i);
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        localparam bit IS_L = (i == int'(REG_L));
        localparam bit IS_H = (i == int'(REG_H));

        logic          eng_we;
        logic [DW-1:0] eng_wd;
        logic          hit_phi, hit_plo, hit_byte;
        logic [DW-1:0] q;

        // Select the adder write that may target this register.
        always_comb begin
            eng_we = IS_L ? lo_we_i : (IS_H ? hi_we_i : 1'b0);
            eng_wd = IS_L ? lo_wd_i : hi_wd_i;
        end

        // Port write hits for this register.
        always_comb begin
            hit_phi  = pw_ok && (pw_hi == MY_IDX);
            hit_plo  = pw_ok && (pw_lo == MY_IDX);
            hit_byte = byte_we_i && !pair_we_i && (byte_idx_i == MY_IDX);
        end

        // Register update with fixed priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (eng_we) begin
                q <= eng_wd;
            end else if (hit_phi) begin
                q <= pair_wd_i[2*DW-1:DW];
            end else if (hit_plo) begin
                q <= pair_wd_i[DW-1:0];
            end else if (hit_byte) begin
                q <= byte_wd_i;
            end
        end

        assign regs_o[i] = q;
    end

    // R9
    pair_over_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we_i && byte_we_i && (byte_idx_i == REG_A)) |=> $stable(regs_o[REG_A]));

endmodule

// File: rtl/pairreg_file.sv
// Module: top of the byte/pair register file with two-step pair adder.
// Reads are combinational; HL is always presented as the operand address.
// Assumes a synchronous active-low reset.
module pairreg_file
    import pairreg_pkg::*;
#(
    parameter int unsigned DW = 8,
    localparam int unsigned PW = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       byte_rd_idx,
    output logic [DW-1:0]    byte_rd_data,
    input  logic             byte_wr_en,
    input  logic [2:0]       byte_wr_idx,
    input  logic [DW-1:0]    byte_wr_data,
    input  logic [1:0]       pair_rd_sel,
    output logic [PW-1:0]    pair_rd_data,
    input  logic             pair_wr_en,
    input  logic [1:0]       pair_wr_sel,
    input  logic [PW-1:0]    pair_wr_data,
    output logic [PW-1:0]    mem_addr,
    input  logic             add_start,
    input  logic [1:0]       add_src_sel,
    output logic             add_busy,
    output logic             add_done,
    output logic             carry_flag
);

    logic [NUM_REGS-1:0][DW-1:0] regs;
    logic [NUM_REGS:0][DW-1:0]   rview;
    logic                        lo_we, hi_we;
    logic [DW-1:0]               lo_wd, hi_wd;
    logic [PW-1:0]               src_pair;

    pairreg_bank #(.DW(DW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we_i  (byte_wr_en),
        .byte_idx_i (byte_wr_idx),
        .byte_wd_i  (byte_wr_data),
        .pair_we_i  (pair_wr_en),
        .pair_sel_i (pair_wr_sel),
        .pair_wd_i  (pair_wr_data),
        .lo_we_i    (lo_we),
        .lo_wd_i    (lo_wd),
        .hi_we_i    (hi_we),
        .hi_wd_i    (hi_wd),
        .regs_o     (regs)
    );

    // Read view padded with a zero entry for the unused index.
    always_comb begin
        rview = {{DW{1'b0}}, regs};
    end

    // Byte, pair, source-pair and address read muxes.
    always_comb begin
        byte_rd_data = rview[byte_rd_idx];
        pair_rd_data = pair_valid(pair_rd_sel)
                     ? {rview[pair_hi_idx(pair_rd_sel)], rview[pair_lo_idx(pair_rd_sel)]}
                     : '0;
        src_pair     = pair_valid(add_src_sel)
                     ? {rview[pair_hi_idx(add_src_sel)], rview[pair_lo_idx(add_src_sel)]}
                     : '0;
        mem_addr     = {regs[REG_H], regs[REG_L]};
    end

    pairreg_adder #(.DW(DW)) u_adder (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (add_start),
        .src_sel_i (add_src_sel),
        .src_lo_i  (src_pair[DW-1:0]),
        .src_hi_i  (src_pair[PW-1:DW]),
        .l_i       (regs[REG_L]),
        .h_i       (regs[REG_H]),
        .busy_o    (add_busy),
        .done_o    (add_done),
        .carry_o   (carry_flag),
        .lo_we_o   (lo_we),
        .lo_wd_o   (lo_wd),
        .hi_we_o   (hi_we),
        .hi_wd_o   (hi_wd)
    );

    // R3
    bc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_wr_en && (pair_wr_sel == PAIR_BC)) |=>
        ({regs[REG_B], regs[REG_C]} == $past(pair_wr_data)));

endmodule

// File: tb/tb_pairreg_file.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module tb_pairreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  brd_idx = '0;
    logic [7:0]  brd_data;
    logic        bwe = 1'b0;
    logic [2:0]  bidx = '0;
    logic [7:0]  bwd = '0;
    logic [1:0]  prd_sel = '0;
    logic [15:0] prd_data;
    logic        pwe = 1'b0;
    logic [1:0]  psel = '0;
    logic [15:0] pwd = '0;
    logic [15:0] maddr;
    logic        ast = 1'b0;
    logic [1:0]  asel = '0;
    logic        busy, done, carry;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int m_reg[7];
    int m_carry, m_busy, m_done, m_hiop, m_cmid;

    always #10 clk = ~clk;

    pairreg_file dut (
        .clk(clk), .rst_n(rst_n),
        .byte_rd_idx(brd_idx), .byte_rd_data(brd_data),
        .byte_wr_en(bwe), .byte_wr_idx(bidx), .byte_wr_data(bwd),
        .pair_rd_sel(prd_sel), .pair_rd_data(prd_data),
        .pair_wr_en(pwe), .pair_wr_sel(psel), .pair_wr_data(pwd),
        .mem_addr(maddr),
        .add_start(ast), .add_src_sel(asel),
        .add_busy(busy), .add_done(done), .carry_flag(carry)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_pair(input int sel);
        if (sel > 2) return 0;
        return (m_reg[2*sel+1] << 8) | m_reg[2*sel+2];
    endfunction

    // Compare all outputs against the model.
    task automatic compare_all();
        check("R2 byte read", int'(brd_data), (brd_idx < 7) ? m_reg[brd_idx] : 0);
        check("R3 pair read", int'(prd_data), m_pair(int'(prd_sel)));
        check("R4 address", int'(maddr), m_pair(2));
        check("R6 busy", int'(busy), m_busy);
        check("R6 done", int'(done), m_done);
        check("R7 carry", int'(carry), m_carry);
    endtask

    // Model state update for one rising edge.
    task automatic model_edge();
        int nr[7];
        int s;
        nr = m_reg;
        if (bwe && !pwe && bidx < 7) nr[bidx] = int'(bwd);
        if (pwe && psel < 3) begin
            nr[2*psel+1] = int'(pwd) >> 8;
            nr[2*psel+2] = int'(pwd) & 255;
        end
        if (m_busy == 1) begin
            s = m_reg[5] + m_hiop + m_cmid;
            nr[5] = s & 255;
            m_carry = s >> 8;
            m_busy = 0;
            m_done = 1;
        end else begin
            m_done = 0;
            if (ast && asel < 3) begin
                s = m_reg[6] + m_reg[2*asel+2];
                nr[6] = s & 255;
                m_cmid = s >> 8;
                m_hiop = m_reg[2*asel+1];
                m_busy = 1;
            end
        end
        m_reg = nr;
    endtask

    // One cycle: compare, advance model at the edge, release strobes.
    task automatic tick();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bwe = 1'b0; pwe = 1'b0; ast = 1'b0;
    endtask

    task automatic pair_write(input int sel, input int val);
        pwe = 1'b1; psel = 2'(sel); pwd = 16'(val);
        tick();
    endtask

    task automatic start_add(input int sel);
        ast = 1'b1; asel = 2'(sel);
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 7; i++) m_reg[i] = 0;
        m_carry = 0; m_busy = 0; m_done = 0; m_hiop = 0; m_cmid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state while still in reset
        for (int i = 0; i < 7; i++) begin
            brd_idx = 3'(i);
            #1 check("R1 reset reg", int'(brd_data), 0);
        end
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset carry", int'(carry), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: byte writes to every index, including the unused one
        for (int i = 0; i < 8; i++) begin
            bwe = 1'b1; bidx = 3'(i); bwd = 8'(8'h11 * (i + 1));
            brd_idx = 3'(i);
            tick();
        end
        brd_idx = 3'd7;
        #1 check("R2 idx7 read zero", int'(brd_data), 0);
        brd_idx = 3'd5;
        #1 check("R2 H byte", int'(brd_data), 8'h66);

        // R3: pair writes, seen through byte reads; select 3 ignored
        pair_write(0, 16'hB1C2);
        brd_idx = 3'd1; #1 check("R3 B high byte", int'(brd_data), 8'hB1);
        brd_idx = 3'd2; #1 check("R3 C low byte", int'(brd_data), 8'hC2);
        pair_write(1, 16'hD3E4);
        pair_write(3, 16'hFFFF);
        brd_idx = 3'd0; #1 check("R3 sel3 no write A", int'(brd_data), 8'h11);
        prd_sel = 2'd3; #1 check("R3 sel3 read zero", int'(prd_data), 0);
        prd_sel = 2'd1; #1 check("R3 DE read", int'(prd_data), 16'hD3E4);

        // R9: pair write wins, byte write dropped entirely
        bwe = 1'b1; bidx = 3'd0; bwd = 8'h5A;
        pwe = 1'b1; psel = 2'd2; pwd = 16'h12FF;
        tick();
        brd_idx = 3'd0; #1 check("R9 byte write dropped", int'(brd_data), 8'h11);
        #0 check("R4 address HL", int'(maddr), 16'h12FF);

        // R5: low carry propagates into high step
        pair_write(0, 16'h0001);
        start_add(0);
        #1 check("R5 L after start edge", int'(maddr), 16'h1200);
        tick();
        #1 check("R5 HL sum", int'(maddr), 16'h1300);
        check("R7 carry clear", int'(carry), 0);

        // R7: full wrap sets carry; pair write keeps it
        pair_write(2, 16'hFFFF);
        pair_write(1, 16'h0001);
        start_add(1);
        tick();
        #1 check("R7 wrap carry", int'(carry), 1);
        check("R5 wrap sum", int'(maddr), 0);
        pair_write(0, 16'h0000);
        #1 check("R7 carry held", int'(carry), 1);

        // R8: HL + HL
        pair_write(2, 16'h8181);
        start_add(2);
        tick();
        #1 check("R8 doubled HL", int'(maddr), 16'h0302);
        check("R8 carry", int'(carry), 1);

        // R6: start while busy is ignored
        pair_write(0, 16'h0101);
        start_add(0);
        ast = 1'b1; asel = 2'd0;
        tick();
        tick();
        #1 check("R6 second start ignored", int'(busy), 0);
        check("R6 single add result", int'(maddr), 16'h0403);

        // R10: select 3 start ignored
        start_add(3);
        #1 check("R10 no busy", int'(busy), 0);
        check("R10 HL unchanged", int'(maddr), 16'h0403);

        // R11: adder write to H beats byte write; L byte write during busy lands
        start_add(0);
        bwe = 1'b1; bidx = 3'd5; bwd = 8'hAA;
        tick();
        brd_idx = 3'd5; #1 check("R11 adder wins on H", int'(brd_data), 8'h05);
        start_add(0);
        pwe = 1'b1; psel = 2'd2; pwd = 16'hEEEE;
        tick();
        #1 check("R11 adder H, pair L", int'(maddr), 16'h06EE);

        // Random traffic against the model
        for (int n = 0; n < 2000; n++) begin
            bwe = 1'($urandom_range(0, 1));
            bidx = 3'($urandom_range(0, 7));
            bwd = 8'($urandom);
            pwe = ($urandom_range(0, 3) == 0);
            psel = 2'($urandom_range(0, 3));
            pwd = 16'($urandom);
            ast = 1'($urandom_range(0, 1));
            asel = 2'($urandom_range(0, 3));
            brd_idx = 3'($urandom_range(0, 7));
            prd_sel = 2'($urandom_range(0, 3));
            tick();
        end
        tick();
        finish_run();
    end

endmodule